// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator with Flagged Interrupts

This block counts transitions on an external pulse line in an 8-bit register. A control input chooses whether rising or falling transitions are counted. The pulse line is asynchronous to the block clock. It is brought into the clock domain through two flip-flops, and a transition is detected by comparing successive synchronised samples.

Two status flags report activity. One flag is raised each time the counter wraps from its top value back to zero. The other flag is raised on every selected transition. Each flag has its own enable bit in a mask register. The enable gates only the shared interrupt request line and never changes the flag, so software can either poll the flags or service interrupts. Software clears a flag by writing a one to its bit position.

The registers sit on a byte-wide bus with separate read and write strobes and a 2-bit address. Address 0 is the counter, address 1 is the mask and address 2 is the flags. Reads are combinational and have no side effects. Writes take effect at the clock edge on which the write strobe is sampled high.

Top module: `pulse_acc`

## Requirements
- R1: After reset the counter, mask and flag registers all read 0x00 and `irq` is low.
- R2: With `edge_fall` low, each rising transition of `pulse_in` adds one to the counter. The new count is readable after the third rising clock edge that follows the transition.
- R3: With `edge_fall` high, each falling transition of `pulse_in` adds one to the counter, and rising transitions are not counted.
- R4: When a counted transition takes the counter from 0xFF to 0x00, the wrap flag at bit 5 of the flag register (address 2) becomes 1.
- R5: Every selected transition sets the transition flag at bit 4 of the flag register.
- R6: Writing to address 2 clears bit 5 and bit 4 wherever the written data holds a 1. A 0 in either position leaves that flag unchanged.
- R7: If a flag is set and cleared in the same cycle, the flag ends up set.
- R8: A write to address 0 loads the written byte. A counted transition in the same cycle adds nothing, although the transition flag still sets.
- R9: The mask register (address 1) stores bits 7, 6, 5, 4, 1 and 0, and bits 3 and 2 read as 0. Writing the mask never changes the flag register.
- R10: `irq` is high exactly when (flag bit 5 AND mask bit 5) OR (flag bit 4 AND mask bit 4) is true.
- R11: Flag register bits 7, 6 and 3 to 0 always read 0, and writes to them have no effect.
- R12: `rdata` is 0x00 while `rd_en` is low and when address 3 is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse line whose transitions are counted |
| edge_fall | input | 1 | 0 counts rising transitions, 1 counts falling transitions |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 counter, 1 mask, 2 flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| irq | output | 1 | Interrupt request |

## Verification
Trains of rising-edge pulses and falling-edge pulses are applied to check that the mode input selects the counted transition rather than counting both. A preload to 0xFE followed by two pulses checks the wrap flag and the 0xFF-to-0x00 rollover. Clear writes and count writes are placed in exactly the cycle in which a detected transition is registered, which exposes any wrong priority between setting and clearing a flag and between loading and incrementing the counter. Mask values are paired with each flag in turn to show that the interrupt follows the flag-and-enable product and that the enables leave the flags untouched.

// File: rtl/pulse_acc.sv
module pulse_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_in,
  input  logic       edge_fall,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_MSK = 2'd1;
  localparam logic [1:0] A_FLG = 2'd2;
  localparam int         B_WRAP = 5;
  localparam int         B_EDGE = 4;
  localparam logic [7:0] MSK_KEEP = 8'hF3;

  logic [2:0] smp_q;
  logic [7:0] count_q;
  logic [7:0] mask_q;
  logic       wrap_q;
  logic       edge_q;

  logic hit, wr_cnt, wr_msk, wr_flg, step, wrap_set;

  assign hit    = edge_fall ? (~smp_q[1] & smp_q[2]) : (smp_q[1] & ~smp_q[2]);
  assign wr_cnt = wr_en && addr == A_CNT;
  assign wr_msk = wr_en && addr == A_MSK;
  assign wr_flg = wr_en && addr == A_FLG;
  assign step   = hit && !wr_cnt;
  assign wrap_set = step && count_q == 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q   <= '0;
      count_q <= '0;
      mask_q  <= '0;
      wrap_q  <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      smp_q <= {smp_q[1:0], pulse_in};
      if (wr_cnt)
        count_q <= wdata;
      else if (step)
        count_q <= count_q + 8'd1;
      if (wr_msk)
        mask_q <= wdata & MSK_KEEP;
      wrap_q <= wrap_set | (wrap_q & ~(wr_flg & wdata[B_WRAP]));
      edge_q <= hit      | (edge_q & ~(wr_flg & wdata[B_EDGE]));
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      unique case (addr)
        A_CNT:   rdata = count_q;
        A_MSK:   rdata = mask_q;
        A_FLG:   rdata = {2'b00, wrap_q, edge_q, 4'b0000};
        default: rdata = 8'h00;
      endcase
    end
  end

  assign irq = (wrap_q & mask_q[B_WRAP]) | (edge_q & mask_q[B_EDGE]);
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic [7:0] count_q,
  input logic [7:0] mask_q,
  input logic       wrap_q,
  input logic       edge_q,
  input logic       wr_cnt
);
  assert_wrap_rollover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_q) |-> ($past(count_q) == 8'hFF && count_q == 8'h00));

  assert_edge_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(edge_q) && !$past(wr_cnt)) |-> count_q == $past(count_q) + 8'd1);

  assert_count_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count_q == $past(wdata));

  assert_wrap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !(wr_en && addr == 2'd2 && wdata[5])) |=> wrap_q);

  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && !(wr_en && addr == 2'd2 && wdata[4])) |=> edge_q);

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd1) |=> $stable(mask_q));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wrap_q || edge_q));
endmodule

bind pulse_acc pulse_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .count_q(count_q), .mask_q(mask_q), .wrap_q(wrap_q),
  .edge_q(edge_q), .wr_cnt(wr_cnt)
);

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_in = 1'b0;
  logic       edge_fall = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_acc u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .edge_fall(edge_fall),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in = 1'b1;
      repeat (2) @(negedge clk);
      pulse_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1 count", 2'd0, 8'h00);
    expect_reg("R1 mask", 2'd1, 8'h00);
    expect_reg("R1 flags", 2'd2, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rising;
    edge_fall = 1'b0;
    pulses(5);
    expect_reg("R2 rising count", 2'd0, 8'h05);
    expect_reg("R5 edge flag", 2'd2, 8'h10);
    wr(2'd2, 8'h00);
    expect_reg("R6 write zero holds", 2'd2, 8'h10);
    wr(2'd2, 8'h10);
    expect_reg("R6 write one clears", 2'd2, 8'h00);
  endtask

  task automatic t_falling;
    edge_fall = 1'b1;
    wr(2'd0, 8'h00);
    pulses(3);
    expect_reg("R3 falling count", 2'd0, 8'h03);
    edge_fall = 1'b0;
    wr(2'd2, 8'h30);
  endtask

  task automatic t_wrap;
    wr(2'd0, 8'hFE);
    pulses(2);
    expect_reg("R4 rollover count", 2'd0, 8'h00);
    expect_reg("R4 wrap flag", 2'd2, 8'h30);
    wr(2'd2, 8'h20);
    expect_reg("R6 clear wrap only", 2'd2, 8'h10);
  endtask

  task automatic t_mask_irq;
    wr(2'd1, 8'hFF);
    expect_reg("R9 mask readback", 2'd1, 8'hF3);
    expect_reg("R9 flags untouched", 2'd2, 8'h10);
    check("R10 irq edge enabled", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h20);
    check("R10 irq edge masked", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h30);
    wr(2'd0, 8'hFF);
    pulses(1);
    check("R10 irq wrap enabled", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h20);
    check("R10 irq after wrap clear", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    expect_reg("R9 mask clear keeps flags", 2'd2, 8'h10);
    wr(2'd2, 8'h30);
  endtask

  task automatic t_unused_bits;
    logic [7:0] v;
    pulses(1);
    wr(2'd2, 8'hCF);
    expect_reg("R11 unused flag bits", 2'd2, 8'h10);
    expect_reg("R12 address 3", 2'd3, 8'h00);
    @(negedge clk);
    rd_en = 1'b0; addr = 2'd2;
    #1 v = rdata;
    check("R12 idle read", v, 8'h00);
  endtask

  task automatic t_set_wins;
    @(negedge clk); pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 8'h10;
    @(negedge clk); wr_en = 1'b0; pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    expect_reg("R7 set beats clear", 2'd2, 8'h10);
    wr(2'd2, 8'h30);
    expect_reg("R6 cleared before R8", 2'd2, 8'h00);
  endtask

  task automatic t_load_vs_edge;
    @(negedge clk); pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
    @(negedge clk); wr_en = 1'b0; pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    expect_reg("R8 load wins", 2'd0, 8'h40);
    expect_reg("R8 edge flag still set", 2'd2, 8'h10);
    pulses(1);
    expect_reg("R8 counting resumes", 2'd0, 8'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_rising;
    t_falling;
    t_wrap;
    t_mask_irq;
    t_unused_bits;
    t_set_wins;
    t_load_vs_edge;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule